// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges six reset requests into a single active-low system reset. The requests are power-on, an external reset pad, an independent watchdog, a window watchdog, a debug-port reset and illegal-instruction detection. Every accepted request loads a pulse stretcher. The stretcher holds the system reset for a guaranteed minimum time. For that same time it pulls the shared open-drain pad low, so that devices outside the chip are reset along with it.

The pad is sampled by a synchronizer that runs on the free-running reset-domain oscillator, so a halted CPU clock does not stop external reset detection. A low level is accepted only once it has lasted the minimum filter width. The filter ignores the pad while the block drives it, and for a short blanking window after release, so the block's own echo cannot re-trigger it. The system reset asserts as soon as the stretcher becomes active. Its release passes through a two-stage synchronizer.

A sticky cause register records which sources took part in the last reset, and software clears it with write-one-to-clear. The block also presents the fixed boot vector that the processor fetches after release.

Top module: `rst_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst_n_o` is 0, `pad_oe_o` is 1, `cause_o` equals 6'b000001 and `boot_vec_o` reads 16'h8000.
- R2: After `por_n` rises, `sys_rst_n_o` stays low for at least PULSE_CYC and at most PULSE_CYC+3 clock cycles, where PULSE_CYC = ceil(PULSE_NS*1000/CLK_PERIOD_PS), then goes high.
- R3: A one-cycle request on `req_iwdg_i`, `req_wwdg_i`, `req_dbg_i` or `req_ill_i` drives `sys_rst_n_o` low from the next clock edge for between PULSE_CYC and PULSE_CYC+3 cycles.
- R4: When `pad_i` is held low for FILT_CYC or more consecutive cycles, where FILT_CYC = ceil(FILT_NS*1000/CLK_PERIOD_PS), a reset is started and cause bit 1 is set.
- R5: When `pad_i` is held low for FILT_CYC-1 cycles or fewer, no reset occurs and `sys_rst_n_o` stays 1.
- R6: `pad_oe_o` is 1 for the whole time the reset pulse is active. Whenever `pad_oe_o` is 1, `sys_rst_n_o` is 0.
- R7: The block's own drive of the pad, which is seen back on `pad_i`, never starts a further reset after the pulse ends.
- R8: A request that arrives while the pulse is active restarts the count, so the reset lasts at least PULSE_CYC cycles after the last request.
- R9: The cause bits are 0 for power-on, 1 for the pad, 2 for the independent watchdog, 3 for the window watchdog, 4 for debug and 5 for illegal instruction. Each request sets its bit, and bits accumulate. A write with `clr_we_i` clears the bits set in `clr_mask_i`, and a set in the same cycle wins over the clear.
- R10: `boot_vec_o` always equals BOOT_VEC, which defaults to 16'h8000.
- R11: `sys_rst_n_o` rises only after `pad_oe_o` has been low on each of the two preceding clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reset-domain oscillator |
| por_n | input | 1 | Power-on detector output, active low, asynchronous |
| pad_i | input | 1 | Sensed level of the open-drain reset pad |
| pad_oe_o | output | 1 | Pulls the pad low when 1 |
| req_iwdg_i | input | 1 | Independent watchdog reset request |
| req_wwdg_i | input | 1 | Window watchdog reset request |
| req_dbg_i | input | 1 | Debug-port reset request |
| req_ill_i | input | 1 | Illegal-instruction reset request |
| clr_we_i | input | 1 | Write strobe for clearing cause bits |
| clr_mask_i | input | 6 | Cause bits to clear (write one to clear) |
| sys_rst_n_o | output | 1 | System reset, active low |
| cause_o | output | 6 | Sticky reset cause flags |
| boot_vec_o | output | VEC_W | Boot vector fetched after release |

## Verification
The assertions assume that the internal request lines and the clear strobe are synchronous to `clk`. They also assume that `por_n` is the only asynchronous input besides the pad. The bench changes every such input at the falling clock edge. It models the pad as a wired-AND of the block's own drive and an external pull-down, so the echo the filter must ignore appears exactly as it would on a board. It holds external pulses for whole clock periods so that the number of low samples the filter sees is known.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned NSRC     = 6;
  localparam int unsigned IDX_POR  = 0;
  localparam int unsigned IDX_PAD  = 1;
  localparam int unsigned IDX_IWDG = 2;
  localparam int unsigned IDX_WWDG = 3;
  localparam int unsigned IDX_DBG  = 4;
  localparam int unsigned IDX_ILL  = 5;

  function automatic int unsigned ceil_cycles(input int unsigned len_ns,
                                              input int unsigned period_ps);
    longint unsigned num;
    num = longint'(len_ns) * 1000;
    return int'((num + period_ps - 1) / period_ps);
  endfunction
endpackage

// File: rtl/rstc_pad_filter.sv
module rstc_pad_filter #(
  parameter int unsigned FILT_CYC  = 3,
  parameter int unsigned BLANK_CYC = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pad_i,
  input  logic self_drive_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam int unsigned BW = $clog2(BLANK_CYC + 1);

  logic [1:0]    sync_q, sync_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] blank_q, blank_d;
  logic          pad_low, masked;

  assign pad_low = ~sync_q[1];
  assign masked  = self_drive_i | (blank_q != '0);

  always_comb begin
    sync_d  = {sync_q[0], pad_i};
    blank_d = blank_q;
    if (self_drive_i)
      blank_d = BW'(BLANK_CYC);
    else if (blank_q != '0)
      blank_d = blank_q - 1'b1;
    cnt_d = cnt_q;
    if (masked || !pad_low)
      cnt_d = '0;
    else if (cnt_q != CW'(FILT_CYC))
      cnt_d = cnt_q + 1'b1;
    hit_o = !masked && pad_low && (cnt_q == CW'(FILT_CYC - 1));
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q  <= 2'b11;
      cnt_q   <= '0;
      blank_q <= '0;
    end else begin
      sync_q  <= sync_d;
      cnt_q   <= cnt_d;
      blank_q <= blank_d;
    end
  end
endmodule

// File: rtl/rstc_pulse_gen.sv
module rstc_pulse_gen #(
  parameter int unsigned PULSE_CYC = 200
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(PULSE_CYC);

  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (req_i) begin
      act_d = 1'b1;
      cnt_d = CW'(PULSE_CYC - 1);
    end else if (act_q) begin
      if (cnt_q == '0)
        act_d = 1'b0;
      else
        cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      act_q <= 1'b1;
      cnt_q <= CW'(PULSE_CYC - 1);
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/rstc_rel_sync.sv
module rstc_rel_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] stg_q, stg_d;

  always_comb stg_d = {stg_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= '0;
    else         stg_q <= stg_d;
  end

  assign rst_n_o = stg_q[STAGES-1];
endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] cause_o
);
  logic [N-1:0] q, d, clr_eff;

  always_comb begin
    clr_eff = clr_we_i ? clr_i : '0;
    d       = (q & ~clr_eff) | set_i;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= N'(1);
    else         q <= d;
  end

  assign cause_o = q;
endmodule

// File: rtl/rst_ctrl.sv
module rst_ctrl
  import rstc_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 100000,
  parameter int unsigned FILT_NS       = 300,
  parameter int unsigned PULSE_NS      = 20000,
  parameter int unsigned BLANK_CYC     = 4,
  parameter int unsigned VEC_W         = 16,
  parameter logic [VEC_W-1:0] BOOT_VEC = 16'h8000
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             pad_i,
  output logic             pad_oe_o,
  input  logic             req_iwdg_i,
  input  logic             req_wwdg_i,
  input  logic             req_dbg_i,
  input  logic             req_ill_i,
  input  logic             clr_we_i,
  input  logic [5:0]       clr_mask_i,
  output logic             sys_rst_n_o,
  output logic [5:0]       cause_o,
  output logic [VEC_W-1:0] boot_vec_o
);
  localparam int unsigned FILT_RAW  = ceil_cycles(FILT_NS, CLK_PERIOD_PS);
  localparam int unsigned PULSE_RAW = ceil_cycles(PULSE_NS, CLK_PERIOD_PS);
  localparam int unsigned FILT_CYC  = (FILT_RAW < 2) ? 2 : FILT_RAW;
  localparam int unsigned PULSE_CYC = (PULSE_RAW < 2) ? 2 : PULSE_RAW;
  localparam int unsigned BLANK_EFF = (BLANK_CYC < 3) ? 3 : BLANK_CYC;

  logic            pad_hit, any_req, active, rel_arst_n;
  logic [NSRC-1:0] set_vec;

  rstc_pad_filter #(.FILT_CYC(FILT_CYC), .BLANK_CYC(BLANK_EFF)) u_filt (
    .clk(clk), .arst_n(por_n), .pad_i(pad_i),
    .self_drive_i(active), .hit_o(pad_hit)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[IDX_PAD]  = pad_hit;
    set_vec[IDX_IWDG] = req_iwdg_i;
    set_vec[IDX_WWDG] = req_wwdg_i;
    set_vec[IDX_DBG]  = req_dbg_i;
    set_vec[IDX_ILL]  = req_ill_i;
    any_req           = |set_vec;
  end

  rstc_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .arst_n(por_n), .req_i(any_req), .active_o(active)
  );

  assign rel_arst_n = por_n & ~active;

  rstc_rel_sync #(.STAGES(2)) u_rel (
    .clk(clk), .arst_n(rel_arst_n), .rst_n_o(sys_rst_n_o)
  );

  rstc_cause_reg #(.N(NSRC)) u_cause (
    .clk(clk), .arst_n(por_n), .set_i(set_vec),
    .clr_we_i(clr_we_i), .clr_i(clr_mask_i), .cause_o(cause_o)
  );

  assign pad_oe_o   = active;
  assign boot_vec_o = BOOT_VEC;
endmodule

// File: rtl/rst_ctrl_sva.sv
module rst_ctrl_sva (
  input logic       clk,
  input logic       por_n,
  input logic       pad_oe_o,
  input logic       sys_rst_n_o,
  input logic       req_iwdg_i,
  input logic       req_wwdg_i,
  input logic       req_dbg_i,
  input logic       req_ill_i,
  input logic [5:0] cause_o
);
  a_r6_oe_holds_reset: assert property (@(posedge clk) disable iff (!por_n)
    pad_oe_o |-> !sys_rst_n_o);

  a_r3_req_starts_pulse: assert property (@(posedge clk) disable iff (!por_n)
    (req_iwdg_i | req_wwdg_i | req_dbg_i | req_ill_i) |=> (pad_oe_o && !sys_rst_n_o));

  a_r9_iwdg_flag: assert property (@(posedge clk) disable iff (!por_n)
    req_iwdg_i |=> cause_o[2]);

  a_r9_ill_flag: assert property (@(posedge clk) disable iff (!por_n)
    req_ill_i |=> cause_o[5]);

  a_r11_sync_release: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n_o) |-> (!$past(pad_oe_o) && !$past(pad_oe_o, 2)));

  a_r2_release_lags_oe: assert property (@(posedge clk) disable iff (!por_n)
    $fell(pad_oe_o) |-> !sys_rst_n_o);
endmodule

bind rst_ctrl rst_ctrl_sva u_sva (
  .clk(clk), .por_n(por_n), .pad_oe_o(pad_oe_o), .sys_rst_n_o(sys_rst_n_o),
  .req_iwdg_i(req_iwdg_i), .req_wwdg_i(req_wwdg_i), .req_dbg_i(req_dbg_i),
  .req_ill_i(req_ill_i), .cause_o(cause_o)
);

// File: tb/rst_ctrl_tb.sv
`timescale 1ns/1ps
module rst_ctrl_tb;
  localparam int CLK_NS = 100;
  localparam int PULSE  = 200;
  localparam int FILT   = 3;

  logic       clk = 1'b0;
  logic       por_n, ext_lo, pad_i, pad_oe;
  logic       r_iwdg, r_wwdg, r_dbg, r_ill, clr_we;
  logic [5:0] clr_mask, cause;
  logic       sys_rst_n;
  logic [15:0] boot_vec;

  int n_run  = 0;
  int n_fail = 0;

  // table entry: {ill,dbg,wwdg,iwdg} request mask, expected cause bits
  localparam logic [9:0] TBL [5] = '{
    {4'b0001, 6'b000100},
    {4'b0010, 6'b001000},
    {4'b0100, 6'b010000},
    {4'b1000, 6'b100000},
    {4'b0011, 6'b001100}
  };

  always #(CLK_NS/2) clk = ~clk;

  assign pad_i = !(pad_oe || ext_lo);

  rst_ctrl u_dut (
    .clk(clk), .por_n(por_n), .pad_i(pad_i), .pad_oe_o(pad_oe),
    .req_iwdg_i(r_iwdg), .req_wwdg_i(r_wwdg), .req_dbg_i(r_dbg), .req_ill_i(r_ill),
    .clr_we_i(clr_we), .clr_mask_i(clr_mask), .sys_rst_n_o(sys_rst_n),
    .cause_o(cause), .boot_vec_o(boot_vec)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (sys_rst_n === 1'b0 && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_req(input logic [3:0] m);
    {r_ill, r_dbg, r_wwdg, r_iwdg} = m;
    @(negedge clk);
    {r_ill, r_dbg, r_wwdg, r_iwdg} = '0;
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr_mask = 6'h3F;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    por_n = 1'b0; ext_lo = 1'b0;
    {r_ill, r_dbg, r_wwdg, r_iwdg} = '0;
    clr_we = 1'b0; clr_mask = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sys_rst_n === 1'b0, "R1 sys_rst_n", int'(sys_rst_n), 0);
    check(pad_oe === 1'b1, "R1 pad_oe", int'(pad_oe), 1);
    check(cause === 6'b000001, "R1 cause", int'(cause), 1);
    check(boot_vec === 16'h8000, "R10 boot_vec", int'(boot_vec), 'h8000);
    // R2 power-on stretch
    por_n = 1'b1;
    count_low(n);
    check(n >= PULSE && n <= PULSE + 3, "R2 por low cycles", n, PULSE + 2);
    check(cause === 6'b000001, "R9 por cause", int'(cause), 1);
    clear_all();
    check(cause === 6'b000000, "R9 w1c all", int'(cause), 0);

    // table walk: R3, R6, R9
    foreach (TBL[i]) begin
      pulse_req(TBL[i][9:6]);
      check(pad_oe === 1'b1 && sys_rst_n === 1'b0, "R6 oe during pulse",
            int'({pad_oe, sys_rst_n}), 2);
      count_low(n);
      check(n >= PULSE && n <= PULSE + 3, "R3 low cycles", n, PULSE + 2);
      check(pad_oe === 1'b0, "R6 oe released", int'(pad_oe), 0);
      check(cause === TBL[i][5:0], "R9 cause bits", int'(cause), int'(TBL[i][5:0]));
      clear_all();
    end

    // R4 external pad accepted
    ext_lo = 1'b1;
    repeat (FILT) @(negedge clk);
    ext_lo = 1'b0;
    repeat (6) @(negedge clk);
    check(sys_rst_n === 1'b0, "R4 pad reset", int'(sys_rst_n), 0);
    count_low(n);
    check(cause === 6'b000010, "R4 pad cause", int'(cause), 2);
    // R7 no re-trigger from own echo
    repeat (40) @(negedge clk);
    check(sys_rst_n === 1'b1 && pad_oe === 1'b0, "R7 no retrigger",
          int'({sys_rst_n, pad_oe}), 2);
    check(cause === 6'b000010, "R7 cause unchanged", int'(cause), 2);
    clear_all();

    // R5 glitch rejected
    ext_lo = 1'b1;
    repeat (FILT - 1) @(negedge clk);
    ext_lo = 1'b0;
    repeat (12) @(negedge clk);
    check(sys_rst_n === 1'b1 && pad_oe === 1'b0, "R5 glitch ignored",
          int'({sys_rst_n, pad_oe}), 2);
    check(cause === 6'b000000, "R5 cause clear", int'(cause), 0);

    // R8 restart during pulse
    pulse_req(4'b0001);
    repeat (99) @(negedge clk);
    check(sys_rst_n === 1'b0, "R8 still low", int'(sys_rst_n), 0);
    pulse_req(4'b0010);
    count_low(n);
    check(n >= PULSE && n <= PULSE + 3, "R8 restart length", n, PULSE + 2);

    // R9 selective clear and set-wins
    check(cause === 6'b001100, "R9 accumulate", int'(cause), 'hC);
    clr_we = 1'b1; clr_mask = 6'b000100;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
    check(cause === 6'b001000, "R9 selective clear", int'(cause), 8);
    clr_we = 1'b1; clr_mask = 6'b010000; r_dbg = 1'b1;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0; r_dbg = 1'b0;
    check(cause === 6'b011000, "R9 set wins", int'(cause), 'h18);
    count_low(n);
    check(boot_vec === 16'h8000, "R10 boot_vec after", int'(boot_vec), 'h8000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule